// File: doc/BRIEF.md
# Privileged Trap Entry Controller

This block carries out the state changes of trap entry for a hart that runs at machine, hypervisor-supervisor, virtual-supervisor and user levels, and that also has a debug mode. A trap request arrives as a one-cycle valid pulse. The request carries a cause word whose top bit flags an interrupt, plus the exception PC, two trap values, the transformed instruction and a guest-virtual-address flag. Alongside the request, the block samples the current privilege, the virtualisation bit V, the debug state, the per-level breakpoint-to-debug enables, the four delegation registers and the three trap-vector registers.

From these inputs it picks where the trap goes. The choices are to stay in debug mode, to enter debug mode, or to handle the trap at the VS, HS or M level. On the following cycle it presents the new PC, privilege and V. It also raises a one-cycle write strobe for the chosen level and gives the data that the surrounding CSR file stores into that level's cause, epc, tval and status fields. The CSR file, interrupt arbitration and translation-cache flushing are handled elsewhere.

Top module: `trap_entry_ctrl`

## Requirements
- R1: After reset, done, all strobes (m_we, hs_we, vs_we, debug_enter) and spvp_we are 0, pc_out is 0, priv_out is 3 (M) and virt_out is 0. Privilege encodings are U=0, S=1, M=3.
- R2: A trap_valid pulse sampled on a clock edge makes done high for exactly the next cycle. All outputs for that trap change in that same cycle. At most one of m_we, hs_we, vs_we, debug_enter is high.
- R3: When in_debug is high, the new PC is DBG_ENTRY_ADDR for a breakpoint exception (interrupt bit 0, code 3). For any other cause it is DBG_EXC_ADDR. No strobe is raised, and priv_out and virt_out equal the current privilege and V.
- R4: A breakpoint exception outside debug mode raises debug_enter when the enable bit for the current level is set in ebreak_en (bit 0 U, bit 1 S, bit 2 M). In that case pc_out is DBG_ENTRY_ADDR, priv_out is M and virt_out is unchanged.
- R5: For interrupts, the VS mask is hideleg and applies only when V=1 and privilege is U or S. The HS mask is mideleg and applies when privilege is U or S.
- R6: For exceptions, the VS mask is medeleg AND hedeleg and the HS mask is medeleg, under the same level and V conditions as R5.
- R7: A trap goes to VS if its code bit is set in the VS mask, otherwise to HS if set in the HS mask, otherwise to M. A code of XLEN or more always goes to M.
- R8: The new PC is the target vector with bit 0 cleared. If vector bit 0 is set and the trap is an interrupt, 4 times the code is added.
- R9: A VS trap raises vs_we and gives priv_out S, virt_out 1, and cause_wdata equal to the cause minus one for interrupts or the cause unchanged for exceptions. It also gives prev_ie equal to cur_sie, prev_priv equal to the old privilege, and the epc and tval.
- R10: An HS trap raises hs_we and gives priv_out S, virt_out 0, cause_wdata equal to the cause, prev_ie equal to cur_sie, prev_virt equal to the old V and gva_wdata equal to the flag. It also passes tval2 and tinst. spvp_we is high only if the old V was 1, with spvp_wdata equal to bit 0 of the old privilege.
- R11: An M trap raises m_we and gives priv_out M, virt_out 0, prev_ie equal to cur_mie, prev_priv equal to the old privilege, prev_virt equal to the old V and gva_wdata equal to the flag. It also passes the cause, epc, tval, tval2 and tinst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trap_valid | input | 1 | One-cycle trap request |
| trap_cause | input | XLEN | Cause word, top bit set for interrupts |
| trap_epc | input | XLEN | PC of the trapping instruction |
| trap_tval | input | XLEN | Trap value |
| trap_tval2 | input | XLEN | Second trap value (guest physical) |
| trap_tinst | input | XLEN | Transformed instruction |
| trap_gva | input | 1 | Trap value holds a guest virtual address |
| cur_priv | input | 2 | Current privilege |
| cur_virt | input | 1 | Current V |
| in_debug | input | 1 | Hart is in debug mode |
| ebreak_en | input | 3 | Breakpoint-to-debug enables {M,S,U} |
| medeleg | input | XLEN | Machine exception delegation |
| mideleg | input | XLEN | Machine interrupt delegation |
| hedeleg | input | XLEN | Hypervisor exception delegation |
| hideleg | input | XLEN | Hypervisor interrupt delegation |
| mtvec | input | XLEN | M trap vector |
| stvec | input | XLEN | HS trap vector |
| vstvec | input | XLEN | VS trap vector |
| cur_sie | input | 1 | Supervisor interrupt enable of the active status view |
| cur_mie | input | 1 | Machine interrupt enable |
| done | output | 1 | Trap entry complete pulse |
| pc_out | output | XLEN | New PC |
| priv_out | output | 2 | New privilege |
| virt_out | output | 1 | New V |
| debug_enter | output | 1 | Strobe: enter debug mode |
| m_we | output | 1 | Strobe: write M trap registers and status |
| hs_we | output | 1 | Strobe: write HS trap registers and status |
| vs_we | output | 1 | Strobe: write VS trap registers and status |
| cause_wdata | output | XLEN | Cause value to store |
| epc_wdata | output | XLEN | EPC value to store |
| tval_wdata | output | XLEN | Trap value to store |
| tval2_wdata | output | XLEN | Second trap value to store (HS, M) |
| tinst_wdata | output | XLEN | Transformed instruction to store (HS, M) |
| prev_ie | output | 1 | Previous interrupt enable for the PIE field |
| prev_priv | output | 2 | Previous privilege for the PP field |
| prev_virt | output | 1 | Previous V for the PV field |
| gva_wdata | output | 1 | GVA field value |
| spvp_we | output | 1 | Strobe: write hypervisor previous-privilege field |
| spvp_wdata | output | 1 | Hypervisor previous-privilege value |

## Verification
The case hardest to reach from the ports is a trap whose code bit is set in both the VS and HS masks while V=1 at a low privilege. Only the priority order then separates a correct design from one that checks HS first. A close second is the out-of-range code, which would alias onto a mask bit if the index were truncated. The bench sweeps every privilege, V, interrupt flag and vector mode. It crosses them with delegation patterns in which the same bit sits in several masks at once, and with codes at 31, 32 and 40, so that both situations come up many times.

// File: rtl/trap_pkg.sv
package trap_pkg;

  typedef enum logic [1:0] {
    PRIV_U   = 2'd0,
    PRIV_S   = 2'd1,
    PRIV_RSV = 2'd2,
    PRIV_M   = 2'd3
  } priv_e;

  typedef enum logic [2:0] {
    TGT_DBG_STAY  = 3'd0,
    TGT_DBG_ENTER = 3'd1,
    TGT_VS        = 3'd2,
    TGT_HS        = 3'd3,
    TGT_M         = 3'd4
  } tgt_e;

  localparam int unsigned BRKPT_CODE = 3;

endpackage

// File: rtl/trap_router.sv
module trap_router
  import trap_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] cause,
  input  priv_e           priv,
  input  logic            virt,
  input  logic            in_debug,
  input  logic [2:0]      ebreak_en,
  input  logic [XLEN-1:0] medeleg,
  input  logic [XLEN-1:0] mideleg,
  input  logic [XLEN-1:0] hedeleg,
  input  logic [XLEN-1:0] hideleg,
  output tgt_e            target,
  output logic            is_brk,
  output logic            vs_hit,
  output logic            hs_hit
);
  localparam int unsigned IW = $clog2(XLEN);

  logic            intr;
  logic [XLEN-2:0] code;
  logic            in_range;
  logic [IW-1:0]   bit_sel;
  logic            low_lvl;
  logic [XLEN-1:0] vs_mask;
  logic [XLEN-1:0] hs_mask;
  logic            ebrk_hit;

  assign intr     = cause[XLEN-1];
  assign code     = cause[XLEN-2:0];
  assign in_range = code < (XLEN-1)'(XLEN);
  assign bit_sel  = code[IW-1:0];
  assign low_lvl  = (priv == PRIV_U) || (priv == PRIV_S);

  // Interrupts and exceptions use different delegation sources.
  assign vs_mask = (virt && low_lvl) ? (intr ? hideleg : (medeleg & hedeleg)) : '0;
  assign hs_mask = low_lvl ? (intr ? mideleg : medeleg) : '0;

  assign vs_hit = in_range && vs_mask[bit_sel];
  assign hs_hit = in_range && hs_mask[bit_sel];
  assign is_brk = !intr && (code == (XLEN-1)'(BRKPT_CODE));

  always_comb begin
    case (priv)
      PRIV_M:  ebrk_hit = ebreak_en[2];
      PRIV_S:  ebrk_hit = ebreak_en[1];
      PRIV_U:  ebrk_hit = ebreak_en[0];
      default: ebrk_hit = 1'b0;
    endcase
  end

  always_comb begin
    if (in_debug)                target = TGT_DBG_STAY;
    else if (is_brk && ebrk_hit) target = TGT_DBG_ENTER;
    else if (vs_hit)             target = TGT_VS;
    else if (hs_hit)             target = TGT_HS;
    else                         target = TGT_M;
  end

endmodule

// File: rtl/trap_vector_calc.sv
module trap_vector_calc #(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] tvec,
  input  logic            intr,
  input  logic [XLEN-3:0] code_lo,
  output logic [XLEN-1:0] pc
);
  function automatic logic [XLEN-1:0] vec_pc(input logic [XLEN-1:0] tv,
                                              input logic            irq,
                                              input logic [XLEN-3:0] c);
    logic [XLEN-1:0] base;
    logic [XLEN-1:0] offs;
    base = {tv[XLEN-1:1], 1'b0};
    offs = (tv[0] && irq) ? {c, 2'b00} : '0;
    return base + offs;
  endfunction

  assign pc = vec_pc(tvec, intr, code_lo);

endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
  import trap_pkg::*;
#(
  parameter int unsigned     XLEN           = 32,
  parameter logic [XLEN-1:0] DBG_ENTRY_ADDR = 'h800,
  parameter logic [XLEN-1:0] DBG_EXC_ADDR   = 'h808
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trap_valid,
  input  logic [XLEN-1:0] trap_cause,
  input  logic [XLEN-1:0] trap_epc,
  input  logic [XLEN-1:0] trap_tval,
  input  logic [XLEN-1:0] trap_tval2,
  input  logic [XLEN-1:0] trap_tinst,
  input  logic            trap_gva,
  input  logic [1:0]      cur_priv,
  input  logic            cur_virt,
  input  logic            in_debug,
  input  logic [2:0]      ebreak_en,
  input  logic [XLEN-1:0] medeleg,
  input  logic [XLEN-1:0] mideleg,
  input  logic [XLEN-1:0] hedeleg,
  input  logic [XLEN-1:0] hideleg,
  input  logic [XLEN-1:0] mtvec,
  input  logic [XLEN-1:0] stvec,
  input  logic [XLEN-1:0] vstvec,
  input  logic            cur_sie,
  input  logic            cur_mie,
  output logic            done,
  output logic [XLEN-1:0] pc_out,
  output logic [1:0]      priv_out,
  output logic            virt_out,
  output logic            debug_enter,
  output logic            m_we,
  output logic            hs_we,
  output logic            vs_we,
  output logic [XLEN-1:0] cause_wdata,
  output logic [XLEN-1:0] epc_wdata,
  output logic [XLEN-1:0] tval_wdata,
  output logic [XLEN-1:0] tval2_wdata,
  output logic [XLEN-1:0] tinst_wdata,
  output logic            prev_ie,
  output logic [1:0]      prev_priv,
  output logic            prev_virt,
  output logic            gva_wdata,
  output logic            spvp_we,
  output logic            spvp_wdata
);
  tgt_e            target;
  logic            is_brk;
  logic            vs_hit;
  logic            hs_hit;
  logic            is_intr;
  logic [XLEN-1:0] sel_tvec;
  logic [XLEN-1:0] vec_pc;
  priv_e           priv_in;

  assign priv_in = priv_e'(cur_priv);
  assign is_intr = trap_cause[XLEN-1];

  trap_router #(.XLEN(XLEN)) u_router (
    .cause     (trap_cause),
    .priv      (priv_in),
    .virt      (cur_virt),
    .in_debug  (in_debug),
    .ebreak_en (ebreak_en),
    .medeleg   (medeleg),
    .mideleg   (mideleg),
    .hedeleg   (hedeleg),
    .hideleg   (hideleg),
    .target    (target),
    .is_brk    (is_brk),
    .vs_hit    (vs_hit),
    .hs_hit    (hs_hit)
  );

  always_comb begin
    case (target)
      TGT_VS:  sel_tvec = vstvec;
      TGT_HS:  sel_tvec = stvec;
      default: sel_tvec = mtvec;
    endcase
  end

  trap_vector_calc #(.XLEN(XLEN)) u_vec (
    .tvec    (sel_tvec),
    .intr    (is_intr),
    .code_lo (trap_cause[XLEN-3:0]),
    .pc      (vec_pc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done        <= 1'b0;
      pc_out      <= '0;
      priv_out    <= PRIV_M;
      virt_out    <= 1'b0;
      debug_enter <= 1'b0;
      m_we        <= 1'b0;
      hs_we       <= 1'b0;
      vs_we       <= 1'b0;
      cause_wdata <= '0;
      epc_wdata   <= '0;
      tval_wdata  <= '0;
      tval2_wdata <= '0;
      tinst_wdata <= '0;
      prev_ie     <= 1'b0;
      prev_priv   <= 2'd0;
      prev_virt   <= 1'b0;
      gva_wdata   <= 1'b0;
      spvp_we     <= 1'b0;
      spvp_wdata  <= 1'b0;
    end else begin
      done        <= trap_valid;
      debug_enter <= 1'b0;
      m_we        <= 1'b0;
      hs_we       <= 1'b0;
      vs_we       <= 1'b0;
      spvp_we     <= 1'b0;
      if (trap_valid) begin
        case (target)
          TGT_DBG_STAY: begin
            pc_out   <= is_brk ? DBG_ENTRY_ADDR : DBG_EXC_ADDR;
            priv_out <= cur_priv;
            virt_out <= cur_virt;
          end
          TGT_DBG_ENTER: begin
            debug_enter <= 1'b1;
            pc_out      <= DBG_ENTRY_ADDR;
            priv_out    <= PRIV_M;
            virt_out    <= cur_virt;
            prev_priv   <= cur_priv;
            epc_wdata   <= trap_epc;
          end
          TGT_VS: begin
            vs_we       <= 1'b1;
            pc_out      <= vec_pc;
            priv_out    <= PRIV_S;
            virt_out    <= 1'b1;
            cause_wdata <= is_intr ? (trap_cause - XLEN'(1)) : trap_cause;
            epc_wdata   <= trap_epc;
            tval_wdata  <= trap_tval;
            prev_ie     <= cur_sie;
            prev_priv   <= cur_priv;
          end
          TGT_HS: begin
            hs_we       <= 1'b1;
            pc_out      <= vec_pc;
            priv_out    <= PRIV_S;
            virt_out    <= 1'b0;
            cause_wdata <= trap_cause;
            epc_wdata   <= trap_epc;
            tval_wdata  <= trap_tval;
            tval2_wdata <= trap_tval2;
            tinst_wdata <= trap_tinst;
            prev_ie     <= cur_sie;
            prev_priv   <= cur_priv;
            prev_virt   <= cur_virt;
            gva_wdata   <= trap_gva;
            spvp_we     <= cur_virt;
            spvp_wdata  <= cur_priv[0];
          end
          default: begin
            m_we        <= 1'b1;
            pc_out      <= vec_pc;
            priv_out    <= PRIV_M;
            virt_out    <= 1'b0;
            cause_wdata <= trap_cause;
            epc_wdata   <= trap_epc;
            tval_wdata  <= trap_tval;
            tval2_wdata <= trap_tval2;
            tinst_wdata <= trap_tinst;
            prev_ie     <= cur_mie;
            prev_priv   <= cur_priv;
            prev_virt   <= cur_virt;
            gva_wdata   <= trap_gva;
          end
        endcase
      end
    end
  end

  AST_DONE_FOLLOWS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |=> done); // R2
  AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({m_we, hs_we, vs_we, debug_enter})); // R2
  AST_DEBUG_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && in_debug) |=> !(m_we || hs_we || vs_we || debug_enter)); // R3
  AST_NO_VS_WITHOUT_VIRT: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && !cur_virt) |=> !vs_we); // R5
  AST_MACHINE_NO_DELEG: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && !in_debug && cur_priv == 2'd3 && !is_brk) |=> m_we); // R6
  AST_VS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    vs_we |-> (virt_out && priv_out == 2'd1)); // R9
  AST_HS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    hs_we |-> (!virt_out && priv_out == 2'd1)); // R10
  AST_SPVP_ONLY_HS: assert property (@(posedge clk) disable iff (!rst_n)
    spvp_we |-> hs_we); // R10
  AST_M_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    m_we |-> (!virt_out && priv_out == 2'd3)); // R11

endmodule

// File: tb/trap_entry_ctrl_bench.sv
`timescale 1ns/1ps
module trap_entry_ctrl_bench;
  localparam logic [31:0] ENTRY = 32'h800;
  localparam logic [31:0] EXCV  = 32'h808;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trap_valid = 1'b0;
  logic [31:0] trap_cause = '0, trap_epc = '0, trap_tval = '0, trap_tval2 = '0, trap_tinst = '0;
  logic        trap_gva = 1'b0;
  logic [1:0]  cur_priv = 2'd3;
  logic        cur_virt = 1'b0, in_debug = 1'b0;
  logic [2:0]  ebreak_en = 3'b000;
  logic [31:0] medeleg = '0, mideleg = '0, hedeleg = '0, hideleg = '0;
  logic [31:0] mtvec = '0, stvec = '0, vstvec = '0;
  logic        cur_sie = 1'b0, cur_mie = 1'b0;

  logic        done, virt_out, debug_enter, m_we, hs_we, vs_we;
  logic [31:0] pc_out, cause_wdata, epc_wdata, tval_wdata, tval2_wdata, tinst_wdata;
  logic [1:0]  priv_out, prev_priv;
  logic        prev_ie, prev_virt, gva_wdata, spvp_we, spvp_wdata;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  trap_entry_ctrl u_trap_entry_ctrl (
    .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .trap_cause(trap_cause),
    .trap_epc(trap_epc), .trap_tval(trap_tval), .trap_tval2(trap_tval2),
    .trap_tinst(trap_tinst), .trap_gva(trap_gva), .cur_priv(cur_priv),
    .cur_virt(cur_virt), .in_debug(in_debug), .ebreak_en(ebreak_en),
    .medeleg(medeleg), .mideleg(mideleg), .hedeleg(hedeleg), .hideleg(hideleg),
    .mtvec(mtvec), .stvec(stvec), .vstvec(vstvec), .cur_sie(cur_sie),
    .cur_mie(cur_mie), .done(done), .pc_out(pc_out), .priv_out(priv_out),
    .virt_out(virt_out), .debug_enter(debug_enter), .m_we(m_we), .hs_we(hs_we),
    .vs_we(vs_we), .cause_wdata(cause_wdata), .epc_wdata(epc_wdata),
    .tval_wdata(tval_wdata), .tval2_wdata(tval2_wdata), .tinst_wdata(tinst_wdata),
    .prev_ie(prev_ie), .prev_priv(prev_priv), .prev_virt(prev_virt),
    .gva_wdata(gva_wdata), .spvp_we(spvp_we), .spvp_wdata(spvp_wdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] code_of(input int i);
    case (i)
      0: return 32'd0;  1: return 32'd1;  2: return 32'd3;  3: return 32'd5;
      4: return 32'd9;  5: return 32'd31; 6: return 32'd32; default: return 32'd40;
    endcase
  endfunction

  task automatic set_deleg(input int p);
    case (p)
      0: begin medeleg = '0; hedeleg = '0; mideleg = '0; hideleg = '0; end
      1: begin medeleg = '1; hedeleg = '1; mideleg = '1; hideleg = '1; end
      2: begin medeleg = 32'hAAAA_AAAA; hedeleg = 32'hFFFF_0000;
               mideleg = 32'h0000_0222; hideleg = 32'h0000_0022; end
      default: begin medeleg = 32'h5555_5555; hedeleg = 32'h0000_FFFF;
               mideleg = 32'h8000_0008; hideleg = 32'h8000_0000; end
    endcase
  endtask

  // Applies the current inputs as one trap and checks every output.
  task automatic run_vec();
    logic        intr;
    logic [30:0] code;
    logic        brk, low, vsd, hsd, ebrk;
    int          tgt;   // 0 dbg stay, 1 dbg enter, 2 VS, 3 HS, 4 M
    logic [31:0] tv, exp_pc;
    string       stag;
    intr = trap_cause[31];
    code = trap_cause[30:0];
    brk  = !intr && code == 31'd3;
    low  = cur_priv < 2'd2;
    ebrk = (cur_priv == 2'd3 && ebreak_en[2]) || (cur_priv == 2'd1 && ebreak_en[1]) ||
           (cur_priv == 2'd0 && ebreak_en[0]);
    vsd = 1'b0; hsd = 1'b0;
    if (code < 31'd32) begin
      vsd = cur_virt && low && (((intr ? hideleg : (medeleg & hedeleg)) >> code[4:0]) & 32'd1) != 0;
      hsd = low && (((intr ? mideleg : medeleg) >> code[4:0]) & 32'd1) != 0;
    end
    if (in_debug) tgt = 0;
    else if (brk && ebrk) tgt = 1;
    else if (vsd) tgt = 2;
    else if (hsd) tgt = 3;
    else tgt = 4;
    tv = (tgt == 2) ? vstvec : (tgt == 3) ? stvec : mtvec;
    exp_pc = (tv & ~32'd1) + ((tv[0] && intr) ? ({1'b0, code} << 2) : 32'd0);
    if (tgt == 0) begin exp_pc = brk ? ENTRY : EXCV; stag = "R3"; end
    else if (tgt == 1) begin exp_pc = ENTRY; stag = "R4"; end
    else if (code >= 31'd32 || (vsd && hsd)) stag = "R7";
    else stag = intr ? "R5" : "R6";

    trap_valid = 1'b1;
    @(negedge clk);
    trap_valid = 1'b0;
    chk("R2 done", {31'd0, done}, 32'd1);
    chk(stag, {28'd0, m_we, hs_we, vs_we, debug_enter},
        {28'd0, tgt == 4, tgt == 3, tgt == 2, tgt == 1});
    chk((tgt < 2) ? stag : "R8", pc_out, exp_pc);
    case (tgt)
      0: chk("R3 priv/virt", {29'd0, priv_out, virt_out}, {29'd0, cur_priv, cur_virt});
      1: chk("R4 priv/virt", {29'd0, priv_out, virt_out}, {29'd0, 2'd3, cur_virt});
      2: begin
        chk("R9 priv/virt", {29'd0, priv_out, virt_out}, {29'd0, 2'd1, 1'b1});
        chk("R9 cause", cause_wdata, intr ? trap_cause - 32'd1 : trap_cause);
        chk("R9 epc/tval", epc_wdata ^ tval_wdata, trap_epc ^ trap_tval);
        chk("R9 status", {29'd0, prev_ie, prev_priv}, {29'd0, cur_sie, cur_priv});
      end
      3: begin
        chk("R10 priv/virt", {29'd0, priv_out, virt_out}, {29'd0, 2'd1, 1'b0});
        chk("R10 cause", cause_wdata, trap_cause);
        chk("R10 data", epc_wdata ^ tval_wdata ^ tval2_wdata ^ tinst_wdata,
            trap_epc ^ trap_tval ^ trap_tval2 ^ trap_tinst);
        chk("R10 status", {27'd0, prev_ie, prev_priv, prev_virt, gva_wdata},
            {27'd0, cur_sie, cur_priv, cur_virt, trap_gva});
        chk("R10 spvp", {30'd0, spvp_we, spvp_we & spvp_wdata},
            {30'd0, cur_virt, cur_virt & cur_priv[0]});
      end
      default: begin
        chk("R11 priv/virt", {29'd0, priv_out, virt_out}, {29'd0, 2'd3, 1'b0});
        chk("R11 cause", cause_wdata, trap_cause);
        chk("R11 data", epc_wdata ^ tval_wdata ^ tval2_wdata ^ tinst_wdata,
            trap_epc ^ trap_tval ^ trap_tval2 ^ trap_tinst);
        chk("R11 status", {27'd0, prev_ie, prev_priv, prev_virt, gva_wdata},
            {27'd0, cur_mie, cur_priv, cur_virt, trap_gva});
      end
    endcase
    if (tgt != 3) chk("R10 spvp idle", {31'd0, spvp_we}, 32'd0);
    @(negedge clk);
    chk("R2 done drop", {28'd0, done, m_we | hs_we | vs_we | debug_enter, 2'd0}, 32'd0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    int n;
    n = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset", {27'd0, done, m_we, hs_we, vs_we, debug_enter}, 32'd0);
    chk("R1 reset", pc_out, 32'd0);
    chk("R1 reset", {29'd0, priv_out, virt_out}, {29'd0, 2'd3, 1'b0});
    chk("R1 reset", {31'd0, spvp_we}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Main sweep over level, V, interrupt flag, code, delegation and vector mode.
    for (int pi = 0; pi < 3; pi++)
      for (int vi = 0; vi < 2; vi++)
        for (int ii = 0; ii < 2; ii++)
          for (int ci = 0; ci < 8; ci++)
            for (int di = 0; di < 4; di++)
              for (int mi = 0; mi < 2; mi++) begin
                n++;
                cur_priv   = (pi == 2) ? 2'd3 : 2'(pi);
                cur_virt   = vi[0];
                trap_cause = {ii[0], 31'(code_of(ci))};
                set_deleg(di);
                mtvec  = 32'h0000_4000 | 32'(mi);
                stvec  = 32'h0000_5000 | 32'(mi);
                vstvec = 32'h0000_6000 | 32'(mi);
                trap_epc   = 32'h1000 + 32'(n) * 4;
                trap_tval  = 32'(n) * 3;
                trap_tval2 = 32'(n) * 5 + 1;
                trap_tinst = 32'(n) * 7 + 2;
                trap_gva   = mi[0] ^ vi[0];
                cur_sie    = ci[0];
                cur_mie    = di[0];
                ebreak_en  = 3'b000;
                run_vec();
              end

    // Debug mode: any cause, no state change beyond the PC.
    in_debug = 1'b1;
    set_deleg(1);
    for (int pi = 0; pi < 3; pi++)
      for (int ii = 0; ii < 2; ii++)
        for (int ci = 0; ci < 8; ci++) begin
          cur_priv   = (pi == 2) ? 2'd3 : 2'(pi);
          cur_virt   = ci[0];
          ebreak_en  = 3'b111;
          trap_cause = {ii[0], 31'(code_of(ci))};
          run_vec();
        end
    in_debug = 1'b0;

    // Breakpoint under every enable combination, with full delegation.
    for (int pi = 0; pi < 3; pi++)
      for (int ei = 0; ei < 8; ei++)
        for (int vi = 0; vi < 2; vi++) begin
          cur_priv   = (pi == 2) ? 2'd3 : 2'(pi);
          cur_virt   = vi[0];
          ebreak_en  = 3'(ei);
          trap_cause = 32'd3;
          trap_epc   = 32'h2000 + 32'(ei);
          run_vec();
        end

    finish_run();
  end

endmodule